// File: doc/BRIEF.md
# Wakeup Interrupt Polarity Normalizer

This block sits between a bank of wakeup interrupt lines and a downstream interrupt controller that only accepts rising-edge pulses and active-high levels. Each pin carries its own 3-bit trigger code. Active-low level sources are inverted before they leave the block. Falling-edge sources are inverted before edge detection, so they come out as rising pulses. Dual-edge sources give a pulse on every transition, in either direction. Every pin can be gated by its own enable bit.

Raw inputs pass through a two-flop synchronizer. Edge-type pins emit a one-cycle pulse on `pin_out` and also set a sticky pending bit. Software clears a pending bit by writing 1 to it. Level-type pins drive `pin_out` straight from the synchronized, polarity-corrected input, with no latching.

Re-coding a pin's polarity while its input is steady must never look like an edge. Any write that changes a pin's code also drops that pin's pending bit. Software reaches the block over a word-addressed register port, with writes taking effect at the clock edge and reads returned combinationally.

Top module: `wakeup_polarity_norm`

## Requirements
- R1: Code 100 (level active-high) makes `pin_out` equal to the enable bit ANDed with the input, two cycles after the raw input changes. It never sets pending.
- R2: Code 000 (level active-low) makes `pin_out` equal to the enable bit ANDed with the inverted input, with the same two-cycle latency. It never sets pending.
- R3: Code 110 (rising edge) turns a 0-to-1 raw transition on an enabled pin into a `pin_out` pulse of exactly one cycle, three cycles after the change. The same edge sets the pin's pending bit. A 1-to-0 transition does nothing.
- R4: Code 010 (falling edge) turns a 1-to-0 raw transition into the same one-cycle rising pulse and sets pending. A 0-to-1 transition does nothing.
- R5: Code 111 (dual edge) gives a one-cycle pulse and sets pending on every raw transition, in either direction.
- R6: A pin whose enable bit is 0 keeps `pin_out` low and never sets its pending bit.
- R7: The enable bit of pin p is bit p%32 of the word at byte address 0x10 + 4*(p/32). Enable words read back what was written.
- R8: The code of pin p is held in bits [2:0] of the word at byte address 0x110 + 4*p. The upper bits are ignored on write and read as 0.
- R9: After reset, every enable bit is 0, every pending bit is 0, every code is 110 and every output is low.
- R10: The pending bit of pin p is bit p%32 of the word at byte address 0x80 + 4*(p/32). Writing 1 to a bit clears it; writing 0 leaves it unchanged.
- R11: When a new qualifying edge and a pending clear land in the same cycle, the pending bit ends up set.
- R12: A write that changes a pin's code clears that pin's pending bit in the same cycle. A write of the code already held leaves pending unchanged.
- R13: Changing the polarity of an edge-type pin while its input is steady produces no pulse and no pending bit.
- R14: The undefined codes 001, 011 and 101 keep `pin_out` low and never set pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_addr | input | ADDR_W (12) | Byte address of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational; 0 for unmapped addresses |
| pin_raw | input | NUM_PINS (168) | Asynchronous raw wakeup inputs |
| pin_out | output | NUM_PINS (168) | Normalized outputs: rising pulses or active-high levels |

## Verification
The embedded properties assume that the write strobe is either 0 or 1, never X, once reset is released. They also assume that a pin's code only changes through the register port, so the change-of-code and clear masks are the sole ways pending can drop. The stimulus drives every bus signal and raw input at the falling clock edge. It holds each raw level for several cycles so the synchronizer resolves cleanly, and it issues one register access at a time. A clear is placed on the same clock edge as a pending set only in the deliberate R11 case.

// File: rtl/wpn_pkg.sv
package wpn_pkg;

    localparam int REG_EN_BASE   = 'h010;
    localparam int REG_PEND_BASE = 'h080;
    localparam int REG_CFG_BASE  = 'h110;

    typedef enum logic [2:0] {
        TRIG_LVL_LO    = 3'b000,
        TRIG_EDGE_FALL = 3'b010,
        TRIG_LVL_HI    = 3'b100,
        TRIG_EDGE_RISE = 3'b110,
        TRIG_EDGE_ANY  = 3'b111
    } trig_kind_e;

    localparam logic [2:0] TRIG_RESET_CODE = TRIG_EDGE_RISE;

    function automatic logic code_inverts(input logic [2:0] code);
        return (code == TRIG_LVL_LO) || (code == TRIG_EDGE_FALL);
    endfunction

    function automatic logic code_is_level(input logic [2:0] code);
        return (code == TRIG_LVL_LO) || (code == TRIG_LVL_HI);
    endfunction

    function automatic logic code_is_edge(input logic [2:0] code);
        return (code == TRIG_EDGE_FALL) || (code == TRIG_EDGE_RISE) ||
               (code == TRIG_EDGE_ANY);
    endfunction

endpackage

// File: rtl/wpn_sync.sv
module wpn_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    typedef struct packed {
        logic [WIDTH-1:0] stage1;
        logic [WIDTH-1:0] stage2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.stage1 = async_in;
        st_d.stage2 = st_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.stage2;

endmodule

// File: rtl/wpn_pin_lane.sv
module wpn_pin_lane
    import wpn_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_in,
    input  logic       en,
    input  logic [2:0] code,
    input  logic       clr_pend,
    input  logic       code_chg,
    output logic       out,
    output logic       pend
);

    typedef struct packed {
        logic prev;
        logic pulse;
        logic pend;
    } lane_t;

    lane_t st_d, st_q;

    logic flip;
    logic now_lvl;
    logic was_lvl;
    logic edge_hit;
    logic hit;

    always_comb begin
        flip     = code_inverts(code);
        // both samples pass through the same inverter, so recoding cannot fake an edge
        now_lvl  = sync_in ^ flip;
        was_lvl  = st_q.prev ^ flip;
        unique case (code)
            TRIG_EDGE_RISE,
            TRIG_EDGE_FALL: edge_hit = now_lvl & ~was_lvl;
            TRIG_EDGE_ANY:  edge_hit = now_lvl ^ was_lvl;
            default:        edge_hit = 1'b0;
        endcase
        hit = edge_hit & en;

        st_d       = st_q;
        st_d.prev  = sync_in;
        st_d.pulse = hit;
        if (hit)                      st_d.pend = 1'b1;
        else if (clr_pend || code_chg) st_d.pend = 1'b0;

        if (code_is_level(code))     out = now_lvl & en;
        else if (code_is_edge(code)) out = st_q.pulse;
        else                         out = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;

    // R6
    pend_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.pend) |-> $past(en));

    // R10
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && !clr_pend && !code_chg) |=> st_q.pend);

    // R12
    code_chg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_chg && !en) |=> !st_q.pend);

    // R14
    undef_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!code_is_level(code) && !code_is_edge(code) && !st_q.pend) |=> !st_q.pend);

    // R3
    pulse_marks_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse |-> st_q.pend);

endmodule

// File: rtl/wpn_regs.sv
module wpn_regs
    import wpn_pkg::*;
#(
    parameter int NUM_PINS = 168,
    parameter int ADDR_W   = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    input  logic [NUM_PINS-1:0]      pend,
    output logic [NUM_PINS-1:0]      en_bits,
    output logic [NUM_PINS-1:0][2:0] code_bits,
    output logic [NUM_PINS-1:0]      clr_mask,
    output logic [NUM_PINS-1:0]      chg_mask
);

    localparam int NUM_WORDS = (NUM_PINS + 31) / 32;
    localparam int PAD_W     = NUM_WORDS * 32;

    typedef struct packed {
        logic [NUM_WORDS-1:0][31:0] en;
        logic [NUM_PINS-1:0][2:0]   code;
    } regs_t;

    regs_t st_d, st_q;

    logic [PAD_W-1:0] pend_pad;
    logic [PAD_W-1:0] en_flat;
    logic             en_written;

    assign pend_pad = PAD_W'(pend);

    always_comb begin
        st_d       = st_q;
        bus_rdata  = '0;
        clr_mask   = '0;
        chg_mask   = '0;
        en_written = 1'b0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (bus_addr == ADDR_W'(REG_EN_BASE + 4 * w)) begin
                bus_rdata = st_q.en[w];
                if (bus_wr) begin
                    st_d.en[w] = bus_wdata;
                    en_written = 1'b1;
                end
            end
            if (bus_addr == ADDR_W'(REG_PEND_BASE + 4 * w)) begin
                bus_rdata = pend_pad[w*32 +: 32];
            end
        end
        for (int p = 0; p < NUM_PINS; p++) begin
            if (bus_addr == ADDR_W'(REG_CFG_BASE + 4 * p)) begin
                bus_rdata = {29'd0, st_q.code[p]};
                if (bus_wr) begin
                    st_d.code[p] = bus_wdata[2:0];
                    chg_mask[p]  = (bus_wdata[2:0] != st_q.code[p]);
                end
            end
            if (bus_wr && (bus_addr == ADDR_W'(REG_PEND_BASE + 4 * (p / 32))) &&
                bus_wdata[p % 32]) begin
                clr_mask[p] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.en   <= '0;
            st_q.code <= {NUM_PINS{TRIG_RESET_CODE}};
        end else begin
            st_q <= st_d;
        end
    end

    assign en_flat   = st_q.en;
    assign en_bits   = en_flat[NUM_PINS-1:0];
    assign code_bits = st_q.code;

    // R7
    en_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_written |=> $stable(st_q.en));

    // R8
    code_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(st_q.code));

    // R12
    chg_needs_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_mask != '0) |-> bus_wr);

endmodule

// File: rtl/wakeup_polarity_norm.sv
module wakeup_polarity_norm #(
    parameter int NUM_PINS = 168,
    parameter int ADDR_W   = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pin_raw,
    output logic [NUM_PINS-1:0] pin_out
);

    logic [NUM_PINS-1:0]      pin_sync;
    logic [NUM_PINS-1:0]      en_bits;
    logic [NUM_PINS-1:0][2:0] code_bits;
    logic [NUM_PINS-1:0]      clr_mask;
    logic [NUM_PINS-1:0]      chg_mask;
    logic [NUM_PINS-1:0]      pend_bits;

    wpn_sync #(.WIDTH(NUM_PINS)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_raw),
        .sync_out (pin_sync)
    );

    wpn_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pend      (pend_bits),
        .en_bits   (en_bits),
        .code_bits (code_bits),
        .clr_mask  (clr_mask),
        .chg_mask  (chg_mask)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_lane
        wpn_pin_lane i_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .sync_in  (pin_sync[p]),
            .en       (en_bits[p]),
            .code     (code_bits[p]),
            .clr_pend (clr_mask[p]),
            .code_chg (chg_mask[p]),
            .out      (pin_out[p]),
            .pend     (pend_bits[p])
        );
    end

endmodule

// File: tb/test_wakeup_polarity_norm.sv
module test_wakeup_polarity_norm;

    localparam int NP = 168;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_raw = '0;
    logic [NP-1:0] pin_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wakeup_polarity_norm #(.NUM_PINS(NP), .ADDR_W(AW)) i_wakeup_polarity_norm (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_raw(pin_raw), .pin_out(pin_out)
    );

    typedef struct packed {
        logic [2:0] code;
        logic       lv0;
        logic       lv1;
        logic [3:0] hi_cnt;
        logic       pend;
    } vec_t;

    localparam vec_t VECS [13] = '{
        '{3'b110, 1'b0, 1'b1, 4'd1, 1'b1},
        '{3'b110, 1'b1, 1'b0, 4'd0, 1'b0},
        '{3'b010, 1'b1, 1'b0, 4'd1, 1'b1},
        '{3'b010, 1'b0, 1'b1, 4'd0, 1'b0},
        '{3'b111, 1'b0, 1'b1, 4'd1, 1'b1},
        '{3'b111, 1'b1, 1'b0, 4'd1, 1'b1},
        '{3'b100, 1'b0, 1'b1, 4'd5, 1'b0},
        '{3'b100, 1'b1, 1'b0, 4'd1, 1'b0},
        '{3'b000, 1'b0, 1'b1, 4'd1, 1'b0},
        '{3'b000, 1'b1, 1'b0, 4'd5, 1'b0},
        '{3'b001, 1'b0, 1'b1, 4'd0, 1'b0},
        '{3'b101, 1'b1, 1'b0, 4'd0, 1'b0},
        '{3'b100, 1'b1, 1'b1, 4'd6, 1'b0}
    };

    function automatic string tag_of(input logic [2:0] c);
        case (c)
            3'b110:  return "R3";
            3'b010:  return "R4";
            3'b111:  return "R5";
            3'b100:  return "R1";
            3'b000:  return "R2";
            default: return "R14";
        endcase
    endfunction

    function automatic logic [AW-1:0] cfg_addr(input int p);
        return AW'('h110 + 4 * p);
    endfunction

    function automatic logic [AW-1:0] en_addr(input int w);
        return AW'('h010 + 4 * w);
    endfunction

    function automatic logic [AW-1:0] pend_addr(input int w);
        return AW'('h080 + 4 * w);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // drive at a falling edge, then count high samples on the next six falling edges
    task automatic drive_count(input int p, input logic lv, output int cnt);
        @(negedge clk);
        pin_raw[p] = lv;
        cnt = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (pin_out[p]) cnt++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int cnt;
        int cnt2;

        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R9 reset state
        for (int w = 0; w < 6; w++) begin
            bus_read(en_addr(w), rd);
            chk("R9 enable word", rd, 32'h0);
        end
        bus_read(pend_addr(0), rd);
        chk("R9 pending word", rd, 32'h0);
        bus_read(cfg_addr(0), rd);
        chk("R9 reset code", rd, 32'h6);
        chk("R9 outputs", 32'(pin_out[31:0]), 32'h0);

        bus_write(en_addr(0), 32'h20);

        for (int v = 0; v < 13; v++) begin
            bus_write(cfg_addr(5), 32'(VECS[v].code));
            pin_raw[5] = VECS[v].lv0;
            idle(6);
            bus_write(pend_addr(0), 32'h20);
            idle(2);
            drive_count(5, VECS[v].lv1, cnt);
            chk({tag_of(VECS[v].code), " output"}, 32'(cnt), 32'(VECS[v].hi_cnt));
            bus_read(pend_addr(0), rd);
            chk({tag_of(VECS[v].code), " pending"}, 32'(rd[5]), 32'(VECS[v].pend));
        end

        // R6 disabled level pin stays low; disabled edge pin has no pulse or pending
        bus_write(cfg_addr(5), 32'h4);
        pin_raw[5] = 1'b1;
        bus_write(en_addr(0), 32'h0);
        idle(2);
        chk("R6 disabled level", 32'(pin_out[5]), 32'h0);
        bus_write(cfg_addr(5), 32'h6);
        pin_raw[5] = 1'b0;
        idle(4);
        drive_count(5, 1'b1, cnt);
        chk("R6 disabled pulse", 32'(cnt), 32'h0);
        bus_read(pend_addr(0), rd);
        chk("R6 disabled pending", rd, 32'h0);
        bus_write(en_addr(0), 32'h20);

        // R7 enable packing across words
        bus_write(en_addr(1), 32'h100);
        bus_write(en_addr(5), 32'h80);
        bus_read(en_addr(1), rd);
        chk("R7 word1 readback", rd, 32'h100);
        bus_read(en_addr(5), rd);
        chk("R7 word5 readback", rd, 32'h80);
        @(negedge clk);
        pin_raw[40] = 1'b1;
        pin_raw[41] = 1'b1;
        cnt = 0; cnt2 = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (pin_out[40]) cnt++;
            if (pin_out[41]) cnt2++;
        end
        chk("R7 pin40 pulse", 32'(cnt), 32'h1);
        chk("R7 pin41 disabled", 32'(cnt2), 32'h0);
        bus_read(pend_addr(1), rd);
        chk("R7 pending word1", rd, 32'h100);

        // R8 config word of last pin, upper bits dropped
        bus_write(cfg_addr(167), 32'hFFFF_FFFC);
        bus_read(cfg_addr(167), rd);
        chk("R8 code readback", rd, 32'h4);
        bus_read(cfg_addr(166), rd);
        chk("R8 neighbour untouched", rd, 32'h6);
        pin_raw[167] = 1'b1;
        idle(3);
        chk("R8 last pin level", 32'(pin_out[167]), 32'h1);

        // R10 write 0 keeps, write 1 clears
        bus_write(cfg_addr(5), 32'h6);
        pin_raw[5] = 1'b0;
        idle(4);
        drive_count(5, 1'b1, cnt);
        bus_write(pend_addr(0), 32'hFFFF_FFDF);
        bus_read(pend_addr(0), rd);
        chk("R10 zero write keeps", 32'(rd[5]), 32'h1);
        bus_write(pend_addr(0), 32'h20);
        bus_read(pend_addr(0), rd);
        chk("R10 one write clears", 32'(rd[5]), 32'h0);

        // R11 set wins over clear in the same cycle
        bus_write(cfg_addr(5), 32'h7);
        drive_count(5, 1'b0, cnt);
        bus_read(pend_addr(0), rd);
        chk("R11 pending before", 32'(rd[5]), 32'h1);
        @(negedge clk);
        pin_raw[5] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = pend_addr(0); bus_wdata = 32'h20;
        @(negedge clk);
        bus_wr = 1'b0;
        idle(2);
        bus_read(pend_addr(0), rd);
        chk("R11 edge beats clear", 32'(rd[5]), 32'h1);

        // R12 same code keeps pending, new code clears it
        bus_write(cfg_addr(5), 32'h7);
        bus_read(pend_addr(0), rd);
        chk("R12 same code keeps", 32'(rd[5]), 32'h1);
        bus_write(cfg_addr(5), 32'h6);
        bus_read(pend_addr(0), rd);
        chk("R12 new code clears", 32'(rd[5]), 32'h0);

        // R13 polarity flip on steady high input
        idle(4);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = cfg_addr(5); bus_wdata = 32'h2;
        @(negedge clk);
        bus_wr = 1'b0;
        cnt = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (pin_out[5]) cnt++;
        end
        chk("R13 no phantom pulse", 32'(cnt), 32'h0);
        bus_read(pend_addr(0), rd);
        chk("R13 no phantom pending", 32'(rd[5]), 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule